// File: doc/BRIEF.md
# Write-Back Cache Tag Controller

This block holds the tag state of a set-associative write-back cache and sequences its misses. It accepts one load or store request at a time, each carrying an address and a byte count. It looks the address up in the tag store and tracks a valid bit and a dirty bit for every way. On a miss it picks a victim way with a pseudo-random generator. It then issues line transfers to the next memory level: a writeback of the evicted line when that line is dirty, followed by a refill of the requested line.

Data storage, byte merging and coherence are outside the block. The controller only owns tag state, miss sequencing and the request port to the next level. A set of running counters reports how many loads and stores arrived, how many of them missed, how many bytes they covered, and how many writebacks were sent. A surrounding cache uses the handshake and the counters to steer its data array and to profile workloads.

Top module: `wb_tag_ctrl`

## Requirements
- R1: After reset every tag entry is invalid, all seven counters read zero, `req_ready` is high and `mem_valid` is low.
- R2: The set index is address bits [OFF+IDX_W-1:OFF], where OFF = log2(LINE_BYTES) and IDX_W = log2(SETS). A request hits when a way of that set is valid and holds the line address (address >> OFF). A hit produces no next-level transfer, and the next request is taken one cycle later.
- R3: A store that hits marks the matching way dirty.
- R4: On a miss the victim way is (next LFSR value) mod WAYS. That way is overwritten in the same cycle with the new line address, marked valid and clean.
- R5: When the evicted entry was valid and dirty, a write transfer (`mem_write`=1) to the victim line address (line << OFF) is issued and the writeback counter increments by one.
- R6: The refill is a read transfer (`mem_write`=0) to the request address with its low OFF bits cleared. It always comes after the writeback, when there is one.
- R7: A store that misses marks the refilled way dirty when the refill handshake completes.
- R8: Every accepted request adds one to the read or write access counter (a store counts as a write) and adds `req_bytes` to the matching byte counter, whether it hits or misses.
- R9: Every accepted request that misses adds one to the read-miss or write-miss counter.
- R10: `req_ready` is low from the cycle after a miss is accepted until the cycle after the refill handshake. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` hold.
- R11: The generator is a 16-bit Fibonacci LFSR: it shifts left, and the new bit 0 is the XOR of bits 15, 13, 12 and 10. It is seeded with SEED at reset and advances exactly once per miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | ADDR_W | Byte address of the access |
| req_bytes | input | BYTES_W | Number of bytes accessed |
| req_store | input | 1 | 1 = store, 0 = load |
| mem_valid | output | 1 | Next-level transfer requested |
| mem_ready | input | 1 | Next level accepts the transfer |
| mem_write | output | 1 | 1 = line writeback, 0 = line refill |
| mem_addr | output | ADDR_W | Line-aligned transfer address |
| stat_rd_acc | output | CNT_W | Load accesses |
| stat_wr_acc | output | CNT_W | Store accesses |
| stat_rd_miss | output | CNT_W | Load misses |
| stat_wr_miss | output | CNT_W | Store misses |
| stat_rd_bytes | output | CNT_W | Bytes loaded |
| stat_wr_bytes | output | CNT_W | Bytes stored |
| stat_wb | output | CNT_W | Writebacks issued |

## Verification
Several properties are checked on every cycle: a stalled transfer holds its address and direction, a writeback handshake is always followed by a refill, a miss always drops `req_ready`, no set ever matches in two ways, the LFSR never reaches zero, and miss counts never exceed access counts. Other behaviour only shows up in the bench scenarios, which compare against a reference model of tags, LFSR and counters. This covers whether the right victim was chosen, whether dirty bits set by store hits and by store misses later produce writebacks to the correct addresses, and whether every counter tracks exactly.

// File: rtl/wbtc_pkg.sv
// Package: shared types and helpers for the write-back tag controller.
// Assumes a 16-bit generator width fixed by the design.
package wbtc_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } ctrl_state_t;

    // One shift of the Fibonacci generator (taps 16,14,13,11).
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

endpackage

// File: rtl/wbtc_lfsr.sv
// Module: victim-selection generator. Holds a 16-bit LFSR and exposes its
// next value; the register advances only when 'step' is asserted.
// Assumes SEED is nonzero.
module wbtc_lfsr
    import wbtc_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [LFSR_W-1:0] nxt
);
    logic [LFSR_W-1:0] cur;

    // Next value offered to the victim picker.
    always_comb nxt = lfsr_step(cur);

    // State register: seed on reset, advance once per miss.
    always_ff @(posedge clk) begin
        if (!rst_n)    cur <= SEED;
        else if (step) cur <= nxt;
    end

    p_lfsr_live_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cur != '0);

endmodule

// File: rtl/wbtc_tag_array.sv
// Module: tag store with valid and dirty bits per way. Gives a combinational
// lookup of one set and a read of one chosen way, and takes one install and
// one dirty-set per cycle. Assumes SETS and WAYS of 2 or more.
module wbtc_tag_array #(
    parameter int SETS   = 4,
    parameter int WAYS   = 2,
    parameter int LINE_W = 28,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [LINE_W-1:0] lk_line,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    input  logic [WAY_W-1:0]  rd_way,
    output logic [LINE_W-1:0] rd_line,
    output logic              rd_valid,
    output logic              rd_dirty,
    input  logic              ins_en,
    input  logic [IDX_W-1:0]  ins_idx,
    input  logic [WAY_W-1:0]  ins_way,
    input  logic [LINE_W-1:0] ins_line,
    input  logic              dty_en,
    input  logic [IDX_W-1:0]  dty_idx,
    input  logic [WAY_W-1:0]  dty_way
);
    logic [LINE_W-1:0] tag_line  [SETS][WAYS];
    logic              tag_valid [SETS][WAYS];
    logic              tag_dirty [SETS][WAYS];
    logic [WAYS-1:0]   hit_vec;

    // Per-way comparators for the looked-up set.
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = tag_valid[lk_idx][w] && (tag_line[lk_idx][w] == lk_line);
    end

    // Encode the matching way.
    always_comb begin
        lk_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (hit_vec[w]) lk_way = WAY_W'(w);
        lk_hit = |hit_vec;
    end

    // Read of the candidate victim before it is replaced.
    always_comb begin
        rd_line  = tag_line[lk_idx][rd_way];
        rd_valid = tag_valid[lk_idx][rd_way];
        rd_dirty = tag_dirty[lk_idx][rd_way];
    end

    // Entry updates: clear on reset, install on miss, mark dirty on store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    tag_line[s][w]  <= '0;
                    tag_valid[s][w] <= 1'b0;
                    tag_dirty[s][w] <= 1'b0;
                end
        end else begin
            if (ins_en) begin
                tag_line[ins_idx][ins_way]  <= ins_line;
                tag_valid[ins_idx][ins_way] <= 1'b1;
                tag_dirty[ins_idx][ins_way] <= 1'b0;
            end
            if (dty_en)
                tag_dirty[dty_idx][dty_way] <= 1'b1;
        end
    end

    p_single_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/wbtc_stats.sv
// Module: running access, miss, byte and writeback counters.
// Assumes CNT_W is wide enough that the counters do not wrap in use.
module wbtc_stats #(
    parameter int CNT_W   = 32,
    parameter int BYTES_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_fire,
    input  logic               acc_store,
    input  logic [BYTES_W-1:0] acc_bytes,
    input  logic               miss_fire,
    input  logic               wb_fire,
    output logic [CNT_W-1:0]   rd_acc,
    output logic [CNT_W-1:0]   wr_acc,
    output logic [CNT_W-1:0]   rd_miss,
    output logic [CNT_W-1:0]   wr_miss,
    output logic [CNT_W-1:0]   rd_bytes,
    output logic [CNT_W-1:0]   wr_bytes,
    output logic [CNT_W-1:0]   wb_cnt
);
    // Counter updates, split by access direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_acc <= '0; wr_acc <= '0; rd_miss <= '0; wr_miss <= '0;
            rd_bytes <= '0; wr_bytes <= '0; wb_cnt <= '0;
        end else begin
            if (acc_fire && !acc_store) begin
                rd_acc   <= rd_acc + 1'b1;
                rd_bytes <= rd_bytes + CNT_W'(acc_bytes);
                if (miss_fire) rd_miss <= rd_miss + 1'b1;
            end
            if (acc_fire && acc_store) begin
                wr_acc   <= wr_acc + 1'b1;
                wr_bytes <= wr_bytes + CNT_W'(acc_bytes);
                if (miss_fire) wr_miss <= wr_miss + 1'b1;
            end
            if (wb_fire) wb_cnt <= wb_cnt + 1'b1;
        end
    end

    p_miss_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_miss <= rd_acc) && (wr_miss <= wr_acc));

endmodule

// File: rtl/wb_tag_ctrl.sv
// Module: write-back cache tag controller top. Accepts one request at a time,
// resolves hit or miss in the acceptance cycle, replaces a random victim,
// then issues a writeback (if the victim was dirty) and a refill to the next
// level. Assumes SETS and LINE_BYTES are powers of two, LINE_BYTES >= 8,
// SETS >= 2 and WAYS >= 2.
module wb_tag_ctrl
    import wbtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SETS       = 4,
    parameter int WAYS       = 2,
    parameter int LINE_BYTES = 16,
    parameter int BYTES_W    = 8,
    parameter int CNT_W      = 32,
    parameter logic [15:0] SEED = 16'hACE1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [BYTES_W-1:0] req_bytes,
    input  logic               req_store,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [CNT_W-1:0]   stat_rd_acc,
    output logic [CNT_W-1:0]   stat_wr_acc,
    output logic [CNT_W-1:0]   stat_rd_miss,
    output logic [CNT_W-1:0]   stat_wr_miss,
    output logic [CNT_W-1:0]   stat_rd_bytes,
    output logic [CNT_W-1:0]   stat_wr_bytes,
    output logic [CNT_W-1:0]   stat_wb
);
    localparam int OFF    = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(SETS);
    localparam int WAY_W  = $clog2(WAYS);
    localparam int LINE_W = ADDR_W - OFF;
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LINE_BYTES - 1);

    ctrl_state_t       state;
    logic [IDX_W-1:0]  lk_idx;
    logic [LINE_W-1:0] lk_line;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic [15:0]       lfsr_nxt;
    logic [WAY_W-1:0]  vic_way;
    logic [LINE_W-1:0] vic_line;
    logic              vic_valid, vic_dirty;
    logic              acc_fire, miss_fire, wb_fire, fill_done;
    logic              dty_en;
    logic [IDX_W-1:0]  dty_idx;
    logic [WAY_W-1:0]  dty_way;
    logic [IDX_W-1:0]  pend_idx;
    logic [WAY_W-1:0]  pend_way;
    logic              pend_store;
    logic [ADDR_W-1:0] pend_addr;
    logic [ADDR_W-1:0] wb_addr;

    // Request decode: set index and line address.
    always_comb begin
        lk_idx  = req_addr[OFF +: IDX_W];
        lk_line = req_addr[ADDR_W-1:OFF];
    end

    // Handshake and event strobes.
    always_comb begin
        req_ready = (state == ST_IDLE);
        acc_fire  = req_valid && req_ready;
        miss_fire = acc_fire && !lk_hit;
        wb_fire   = miss_fire && vic_valid && vic_dirty;
        fill_done = (state == ST_FILL) && mem_ready;
        vic_way   = WAY_W'(lfsr_nxt % 16'(WAYS));
    end

    // Dirty-set source: store hit now, or store miss at refill completion.
    always_comb begin
        dty_en  = 1'b0;
        dty_idx = lk_idx;
        dty_way = lk_way;
        if (acc_fire && lk_hit && req_store) begin
            dty_en = 1'b1;
        end else if (fill_done && pend_store) begin
            dty_en  = 1'b1;
            dty_idx = pend_idx;
            dty_way = pend_way;
        end
    end

    // Next-level request port, driven from registered state only.
    always_comb begin
        mem_valid = (state != ST_IDLE);
        mem_write = (state == ST_WBACK);
        mem_addr  = (state == ST_WBACK) ? wb_addr : pend_addr;
    end

    // Miss sequencer: idle -> optional writeback -> refill -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            pend_idx   <= '0;
            pend_way   <= '0;
            pend_store <= 1'b0;
            pend_addr  <= '0;
            wb_addr    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (miss_fire) begin
                    pend_idx   <= lk_idx;
                    pend_way   <= vic_way;
                    pend_store <= req_store;
                    pend_addr  <= req_addr & ALIGN_MASK;
                    wb_addr    <= {vic_line, OFF'(0)};
                    state      <= (vic_valid && vic_dirty) ? ST_WBACK : ST_FILL;
                end
                ST_WBACK: if (mem_ready) state <= ST_FILL;
                ST_FILL:  if (mem_ready) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    wbtc_lfsr #(.SEED(SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (miss_fire),
        .nxt   (lfsr_nxt)
    );

    wbtc_tag_array #(.SETS(SETS), .WAYS(WAYS), .LINE_W(LINE_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (lk_idx),
        .lk_line  (lk_line),
        .lk_hit   (lk_hit),
        .lk_way   (lk_way),
        .rd_way   (vic_way),
        .rd_line  (vic_line),
        .rd_valid (vic_valid),
        .rd_dirty (vic_dirty),
        .ins_en   (miss_fire),
        .ins_idx  (lk_idx),
        .ins_way  (vic_way),
        .ins_line (lk_line),
        .dty_en   (dty_en),
        .dty_idx  (dty_idx),
        .dty_way  (dty_way)
    );

    wbtc_stats #(.CNT_W(CNT_W), .BYTES_W(BYTES_W)) u_stats (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_fire  (acc_fire),
        .acc_store (req_store),
        .acc_bytes (req_bytes),
        .miss_fire (miss_fire),
        .wb_fire   (wb_fire),
        .rd_acc    (stat_rd_acc),
        .wr_acc    (stat_wr_acc),
        .rd_miss   (stat_rd_miss),
        .wr_miss   (stat_wr_miss),
        .rd_bytes  (stat_rd_bytes),
        .wr_bytes  (stat_wr_bytes),
        .wb_cnt    (stat_wb)
    );

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_ready && mem_write |=> mem_valid && !mem_write);

    p_stall_after_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !lk_hit |=> !req_ready && mem_valid);

endmodule

// File: tb/wb_tag_ctrl_tb.sv
// Bench: reference model of tags, LFSR and counters, compared every cycle.
module wb_tag_ctrl_tb;
    localparam int ADDR_W = 32, SETS = 4, WAYS = 2, LINE_BYTES = 16;
    localparam int BYTES_W = 8, CNT_W = 32, OFF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_store = 1'b0, mem_ready = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BYTES_W-1:0] req_bytes = '0;
    logic req_ready, mem_valid, mem_write;
    logic [ADDR_W-1:0] mem_addr;
    logic [CNT_W-1:0] s_ra, s_wa, s_rm, s_wm, s_rb, s_wb_b, s_wb;

    always #4 clk = ~clk;

    wb_tag_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_store(req_store),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .stat_rd_acc(s_ra), .stat_wr_acc(s_wa),
        .stat_rd_miss(s_rm), .stat_wr_miss(s_wm), .stat_rd_bytes(s_rb),
        .stat_wr_bytes(s_wb_b), .stat_wb(s_wb));

    int checks = 0, errors = 0, cyc = 0;
    bit model_on = 0;

    // Reference state.
    longint m_line [SETS][WAYS];
    bit     m_val  [SETS][WAYS];
    bit     m_dty  [SETS][WAYS];
    logic [15:0] m_lfsr;
    longint m_cnt [7];
    logic [ADDR_W:0] exp_q [$];   // {write, addr}
    int     fill_set, fill_way;
    bit     fill_store;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_line[s][w] = 0; m_val[s][w] = 0; m_dty[s][w] = 0;
            end
        m_lfsr = 16'hACE1;
        for (int i = 0; i < 7; i++) m_cnt[i] = 0;
        exp_q.delete();
    endtask

    // Model update at each clock edge, using values before the edge.
    always @(posedge clk) if (model_on && rst_n) begin
        if (mem_valid && mem_ready && exp_q.size() > 0) begin
            logic [ADDR_W:0] e;
            e = exp_q.pop_front();
            if (e[ADDR_W]) begin
                check(mem_write === 1'b1 && mem_addr === e[ADDR_W-1:0],
                      "R5 R3 R7 writeback transfer", {mem_write, mem_addr}, e);
            end else begin
                check(mem_write === 1'b0 && mem_addr === e[ADDR_W-1:0],
                      "R6 R4 R11 refill transfer", {mem_write, mem_addr}, e);
                if (fill_store) m_dty[fill_set][fill_way] = 1;
            end
        end
        if (req_valid && req_ready) begin
            longint line; int set, hw; bit hit;
            line = longint'(req_addr >> OFF);
            set  = int'(line % SETS);
            hit = 0; hw = 0;
            for (int w = 0; w < WAYS; w++)
                if (m_val[set][w] && m_line[set][w] == line) begin hit = 1; hw = w; end
            if (req_store) begin m_cnt[1]++; m_cnt[5] += req_bytes; end
            else           begin m_cnt[0]++; m_cnt[4] += req_bytes; end
            if (hit) begin
                if (req_store) m_dty[set][hw] = 1;
            end else begin
                int vw;
                if (req_store) m_cnt[3]++; else m_cnt[2]++;
                m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
                vw = int'(m_lfsr) % WAYS;
                if (m_val[set][vw] && m_dty[set][vw]) begin
                    exp_q.push_back({1'b1, ADDR_W'(m_line[set][vw] << OFF)});
                    m_cnt[6]++;
                end
                exp_q.push_back({1'b0, req_addr & ~ADDR_W'(LINE_BYTES - 1)});
                m_line[set][vw] = line; m_val[set][vw] = 1; m_dty[set][vw] = 0;
                fill_set = set; fill_way = vw; fill_store = req_store;
            end
        end
    end

    // Per-cycle comparison, away from the active edge; also drives mem_ready.
    always @(negedge clk) begin
        cyc++;
        mem_ready <= (cyc % 3) != 1;
        if (model_on && rst_n) begin
            check(s_ra == m_cnt[0] && s_wa == m_cnt[1], "R8 access counters", {s_ra, s_wa}, {m_cnt[0][31:0], m_cnt[1][31:0]});
            check(s_rb == m_cnt[4] && s_wb_b == m_cnt[5], "R8 byte counters", {s_rb, s_wb_b}, {m_cnt[4][31:0], m_cnt[5][31:0]});
            check(s_rm == m_cnt[2] && s_wm == m_cnt[3], "R9 miss counters", {s_rm, s_wm}, {m_cnt[2][31:0], m_cnt[3][31:0]});
            check(s_wb == m_cnt[6], "R5 writeback counter", s_wb, m_cnt[6]);
            check(req_ready === (exp_q.size() == 0), "R10 R2 request stall", req_ready, exp_q.size() == 0);
            check(mem_valid === (exp_q.size() != 0), "R10 transfer pending", mem_valid, exp_q.size() != 0);
            if (exp_q.size() != 0)
                check({mem_write, mem_addr} === exp_q[0], "R6 R10 transfer order",
                      {mem_write, mem_addr}, exp_q[0]);
        end
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic [ADDR_W-1:0] a, input bit st, input int nb);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_store = st; req_bytes = BYTES_W'(nb);
        while (!req_ready) @(negedge clk);
    endtask

    task automatic drain();
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        check(req_ready === 1'b1 && mem_valid === 1'b0, "R1 reset handshake", {req_ready, mem_valid}, 2'b10);
        check((s_ra | s_wa | s_rm | s_wm | s_rb | s_wb_b | s_wb) == 0, "R1 reset counters", s_ra | s_wa | s_wb, 0);
        model_on = 1;
        // R2/R3: miss then hits in the same line, store hit dirties it.
        issue(32'h100, 0, 4);
        issue(32'h104, 0, 4);
        issue(32'h10C, 1, 2);
        issue(32'h108, 0, 8);
        // Conflicts in set 0 force evictions, including the dirty line (R5).
        issue(32'h000, 0, 1);
        issue(32'h040, 1, 4);
        issue(32'h080, 0, 2);
        issue(32'h0C0, 1, 8);
        issue(32'h140, 0, 4);
        issue(32'h1C0, 1, 1);
        drain();
        // Store misses in other sets, write-allocate (R7), then re-evict.
        for (int i = 0; i < 12; i++) issue(32'h1000 + 32'(i) * 32'h40 + 32'h10, 1, 4);
        drain();
        // Mixed stream with back-to-back requests.
        for (int i = 0; i < 400; i++)
            issue(32'((i * 52 + (i >> 2) * 448) & 32'hFFF), (i % 3) == 0, 1 << (i % 4));
        drain();
        // Hits on an already present line: no traffic (R2).
        issue(32'h2000, 0, 4);
        drain();
        for (int i = 0; i < 8; i++) issue(32'h2000 + 32'(i), i[0], 1);
        drain();
        repeat (4) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule